// File: doc/BRIEF.md
# Partitioned Pixel-by-Coefficient Fractional Multiplier

This block is a SIMD multiplier for pixel processing. Each lane multiplies an unsigned 8-bit pixel component by a signed 16-bit coefficient. It keeps the middle 16 bits of the 24-bit product, bits 23:8, and rounds that field up by one when product bit 7 is set. The increment wraps within 16 bits.

A 3-bit mode code decides three things: which byte of the first operand feeds each lane, which 16-bit value of the second operand is the coefficient, and where each 16-bit result lands in the 64-bit output. Seven codes are defined and the eighth yields zero. Operand fetch and result writeback belong to the surrounding datapath.

The block is a two-stage pipeline. An input accepted with `in_valid` appears on `out_data`, with `out_valid` high, two clock edges later. Results leave in the order the inputs were accepted.

Top module: `frac_mul_simd`

## Requirements
- R1: For every lane, the 16-bit result equals bits 23:8 of the product of the unsigned pixel byte and the signed 16-bit coefficient, plus one when bit 7 of that product is 1.
- R2: The rounding increment wraps modulo 2^16, so a product field of 0xFFFF with bit 7 set gives 0x0000.
- R3: Mode code 0 (pairwise). Lane i (i = 0..3) multiplies `in_opa[8i+7:8i]` by `in_opb[16i+15:16i]`, and the result is placed at `out_data[16i+15:16i]`.
- R4: Mode codes 1 and 2 (shared coefficient). All four bytes `in_opa[8i+7:8i]` are multiplied by one coefficient: `in_opb[31:16]` for code 1, `in_opb[15:0]` for code 2. Result i is placed at `out_data[16i+15:16i]`.
- R5: Mode codes 3 and 4 (byte of each halfword). Lane i takes `in_opa[16i+15:16i+8]` for code 3 or `in_opa[16i+7:16i]` for code 4, multiplies it by `in_opb[16i+15:16i]`, and places the result at `out_data[16i+15:16i]`.
- R6: Mode codes 5 and 6 (double-width). Only lanes 0 and 1 are used. Lane i takes `in_opa[16i+15:16i+8]` for code 5 or `in_opa[16i+7:16i]` for code 6, and multiplies it by `in_opb[16i+15:16i]`. The 16-bit result is placed at `out_data[32i+22:32i+7]`, and every other output bit is zero.
- R7: Mode code 7 is unused and produces an all-zero result.
- R8: `out_valid` is high exactly two rising edges after each edge that samples `in_valid` high. Results keep input order. `out_data` changes only when a new result is delivered.
- R9: While `rst_n` is sampled low, `out_valid` and `out_data` are cleared to zero.
- R10: Operand bits that the selected mode does not read have no effect on the result. In modes 0, 1 and 2 this covers `in_opa[63:32]`; in modes 1 and 2 it also covers `in_opb[63:32]`; in modes 5 and 6 it covers `in_opa[63:32]` and `in_opb[63:32]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| in_mode | input | 3 | Mode code, 0 to 7 |
| in_opa | input | 64 | Pixel byte operand |
| in_opb | input | 64 | Signed coefficient operand |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Packed rounded lane results |

## Verification
Every result is due two rising edges after the edge that samples its `in_valid`. The bench drives inputs on the falling edge, removes `in_valid` one falling edge later, and samples on the second falling edge after driving, so each comparison falls exactly in the cycle the result register has been loaded. A back-to-back burst checks that `out_valid` is still low one cycle after the first input, that three results then arrive on consecutive cycles in order, and that `out_data` holds through the following idle cycle. The checker asserts the same two-edge valid spacing and the hold of `out_data` while `out_valid` is low.

// File: rtl/frac_mul_pkg.sv
// Shared definitions for the partitioned fractional multiplier.
// Assumes a 3-bit mode code; the encoding is fixed because the bench and
// the surrounding decode depend on it.
package frac_mul_pkg;

    typedef enum logic [2:0] {
        FM_PAIRWISE  = 3'd0,
        FM_SHARED_HI = 3'd1,
        FM_SHARED_LO = 3'd2,
        FM_HI_BYTE   = 3'd3,
        FM_LO_BYTE   = 3'd4,
        FM_WIDE_HI   = 3'd5,
        FM_WIDE_LO   = 3'd6,
        FM_RESERVED  = 3'd7
    } fm_mode_e;

    // True for the two double-width placements.
    function automatic logic fm_is_wide(input fm_mode_e m);
        return (m == FM_WIDE_HI) || (m == FM_WIDE_LO);
    endfunction

endpackage

// File: rtl/fm_operand_route.sv
// Operand router: picks the pixel byte and the coefficient for each lane
// according to the mode. Purely combinational.
// Assumes COEF_W == 2*PIX_W, so that each coefficient halfword holds two
// pixel bytes. Lanes a mode does not use get zero operands, so their
// products are zero.
module fm_operand_route
    import frac_mul_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16,
    parameter int LANES  = 4,
    localparam int DATA_W = LANES * COEF_W
) (
    input  fm_mode_e                  mode,
    input  logic [DATA_W-1:0]         opa,
    input  logic [DATA_W-1:0]         opb,
    output logic [LANES*PIX_W-1:0]    pix_vec,
    output logic [LANES*COEF_W-1:0]   coef_vec
);

    localparam int WIDE_LANES = LANES / 2;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam bit IN_WIDE = (i < WIDE_LANES);

        logic [PIX_W-1:0]  packed_byte;
        logic [PIX_W-1:0]  half_hi;
        logic [PIX_W-1:0]  half_lo;
        logic [COEF_W-1:0] own_coef;

        assign packed_byte = opa[i*PIX_W +: PIX_W];
        assign half_hi     = opa[i*COEF_W + PIX_W +: PIX_W];
        assign half_lo     = opa[i*COEF_W +: PIX_W];
        assign own_coef    = opb[i*COEF_W +: COEF_W];

        // Select this lane's byte and coefficient from the mode.
        always_comb begin
            pix_vec[i*PIX_W +: PIX_W]    = '0;
            coef_vec[i*COEF_W +: COEF_W] = '0;
            unique case (mode)
                FM_PAIRWISE: begin
                    pix_vec[i*PIX_W +: PIX_W]    = packed_byte;
                    coef_vec[i*COEF_W +: COEF_W] = own_coef;
                end
                FM_SHARED_HI: begin
                    pix_vec[i*PIX_W +: PIX_W]    = packed_byte;
                    coef_vec[i*COEF_W +: COEF_W] = opb[COEF_W +: COEF_W];
                end
                FM_SHARED_LO: begin
                    pix_vec[i*PIX_W +: PIX_W]    = packed_byte;
                    coef_vec[i*COEF_W +: COEF_W] = opb[0 +: COEF_W];
                end
                FM_HI_BYTE: begin
                    pix_vec[i*PIX_W +: PIX_W]    = half_hi;
                    coef_vec[i*COEF_W +: COEF_W] = own_coef;
                end
                FM_LO_BYTE: begin
                    pix_vec[i*PIX_W +: PIX_W]    = half_lo;
                    coef_vec[i*COEF_W +: COEF_W] = own_coef;
                end
                FM_WIDE_HI: begin
                    if (IN_WIDE) begin
                        pix_vec[i*PIX_W +: PIX_W]    = half_hi;
                        coef_vec[i*COEF_W +: COEF_W] = own_coef;
                    end
                end
                FM_WIDE_LO: begin
                    if (IN_WIDE) begin
                        pix_vec[i*PIX_W +: PIX_W]    = half_lo;
                        coef_vec[i*COEF_W +: COEF_W] = own_coef;
                    end
                end
                default: begin
                    pix_vec[i*PIX_W +: PIX_W]    = '0;
                    coef_vec[i*COEF_W +: COEF_W] = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/fm_lane_mult.sv
// One lane multiplier: unsigned pixel times signed coefficient.
// The product fits in PIX_W+COEF_W bits as a signed value, because
// (2^PIX_W - 1) * 2^(COEF_W-1) < 2^(PIX_W+COEF_W-1).
module fm_lane_mult #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16,
    localparam int PROD_W = PIX_W + COEF_W
) (
    input  logic [PIX_W-1:0]          pix,
    input  logic [COEF_W-1:0]         coef,
    output logic signed [PROD_W-1:0]  prod
);

    // Extend the pixel with a zero sign bit so the multiply stays signed.
    assign prod = $signed({1'b0, pix}) * $signed(coef);

endmodule

// File: rtl/fm_round_place.sv
// Rounding and placement: takes the middle COEF_W bits of each registered
// product, adds the bit just below them with a wrapping increment, and
// places the lane results according to the mode. Combinational.
// Assumes products of PIX_W+COEF_W bits packed lane by lane.
module fm_round_place
    import frac_mul_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16,
    parameter int LANES  = 4,
    localparam int PROD_W   = PIX_W + COEF_W,
    localparam int DATA_W   = LANES * COEF_W,
    localparam int WIDE_OFS = PIX_W - 1
) (
    input  fm_mode_e                  mode,
    input  logic [LANES*PROD_W-1:0]   prod_vec,
    output logic [DATA_W-1:0]         result
);

    localparam int WIDE_LANES = LANES / 2;

    logic [LANES*COEF_W-1:0] rnd_vec;
    logic [LANES*(PIX_W-1)-1:0] unused_low_bits;

    for (genvar i = 0; i < LANES; i++) begin : g_rnd
        logic [COEF_W-1:0] mid_field;
        logic              round_bit;

        assign mid_field = prod_vec[i*PROD_W + PIX_W +: COEF_W];
        assign round_bit = prod_vec[i*PROD_W + PIX_W - 1];
        assign rnd_vec[i*COEF_W +: COEF_W] = mid_field + {{(COEF_W-1){1'b0}}, round_bit};
        assign unused_low_bits[i*(PIX_W-1) +: (PIX_W-1)] = prod_vec[i*PROD_W +: (PIX_W-1)];
    end

    // Place rounded lanes: packed halfwords, double-width slots, or zero.
    always_comb begin
        result = '0;
        if (mode == FM_RESERVED) begin
            result = '0;
        end else if (fm_is_wide(mode)) begin
            for (int i = 0; i < WIDE_LANES; i++) begin
                result[i*2*COEF_W + WIDE_OFS +: COEF_W] = rnd_vec[i*COEF_W +: COEF_W];
            end
        end else begin
            result = rnd_vec;
        end
    end

endmodule

// File: rtl/frac_mul_simd.sv
// Partitioned pixel-by-coefficient fractional multiplier, top level.
// Stage 1 routes the operands, multiplies every lane and registers the
// products with the mode. Stage 2 rounds, places and registers the result.
// Latency is two clocks, one result per clock, in order. The output data
// holds its value between results. Synchronous active-low reset.
module frac_mul_simd
    import frac_mul_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16,
    parameter int LANES  = 4,
    localparam int DATA_W = LANES * COEF_W,
    localparam int PROD_W = PIX_W + COEF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_mode,
    input  logic [DATA_W-1:0] in_opa,
    input  logic [DATA_W-1:0] in_opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    fm_mode_e                mode_in;
    logic [LANES*PIX_W-1:0]  pix_vec;
    logic [LANES*COEF_W-1:0] coef_vec;
    logic [LANES*PROD_W-1:0] prod_c;

    logic                    s1_valid;
    fm_mode_e                s1_mode;
    logic [LANES*PROD_W-1:0] s1_prod;
    logic [DATA_W-1:0]       res_c;

    assign mode_in = fm_mode_e'(in_mode);

    fm_operand_route #(
        .PIX_W  (PIX_W),
        .COEF_W (COEF_W),
        .LANES  (LANES)
    ) route_i (
        .mode     (mode_in),
        .opa      (in_opa),
        .opb      (in_opb),
        .pix_vec  (pix_vec),
        .coef_vec (coef_vec)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_mul
        logic signed [PROD_W-1:0] lane_prod;

        fm_lane_mult #(
            .PIX_W  (PIX_W),
            .COEF_W (COEF_W)
        ) mult_i (
            .pix  (pix_vec[i*PIX_W +: PIX_W]),
            .coef (coef_vec[i*COEF_W +: COEF_W]),
            .prod (lane_prod)
        );

        assign prod_c[i*PROD_W +: PROD_W] = lane_prod;
    end

    // Stage 1: capture lane products and mode for an accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_mode  <= FM_PAIRWISE;
            s1_prod  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_mode <= mode_in;
                s1_prod <= prod_c;
            end
        end
    end

    fm_round_place #(
        .PIX_W  (PIX_W),
        .COEF_W (COEF_W),
        .LANES  (LANES)
    ) place_i (
        .mode     (s1_mode),
        .prod_vec (s1_prod),
        .result   (res_c)
    );

    // Stage 2: register the placed result and advance the valid pipe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_data <= res_c;
            end
        end
    end

endmodule

// File: rtl/frac_mul_simd_chk.sv
// Checker for the fractional multiplier. It watches only the ports and
// is bound to every instance of the top module.
module frac_mul_simd_chk
    import frac_mul_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_mode,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    logic seen_rst = 1'b0;
    logic armed    = 1'b0;

    // Arm the hold check once a reset has been seen and then released.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
        armed <= rst_n && seen_rst;
    end

    // R8: an accepted input yields out_valid two edges later.
    a_r8_valid_after_two: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R8: no input, no result two edges later.
    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R8: data holds while no result is delivered.
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !out_valid) |-> $stable(out_data));

    // R9: reset clears both outputs.
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    // R7: the unused code produces zero.
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == FM_RESERVED) |-> ##2 (out_data == '0));

    // R6: double-width results leave all bits outside their slots at zero.
    a_r6_wide_gaps_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_mode == FM_WIDE_HI || in_mode == FM_WIDE_LO)) |-> ##2
        (out_data[6:0] == '0 && out_data[38:23] == '0 && out_data[63:55] == '0));

endmodule

bind frac_mul_simd frac_mul_simd_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/frac_mul_simd_tb_top.sv
// Bench for the fractional multiplier: a vector table walked by one loop,
// then directed tests for timing, reset and corner cases.
module frac_mul_simd_tb_top;

    typedef struct packed {
        logic [2:0]  mode;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        use_exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 64'h0000_0000_FFFF_0180, 64'h7FFF_8000_0080_0100, 64'h7F7F_8080_0001_0080, 1'b1},
        '{3'd0, 64'h0000_0000_8180_0201, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_0000_0000_0000, 1'b1},
        '{3'd6, 64'h0000_0000_AA01_BB80, 64'h0000_0000_0080_0100, 64'h0000_0080_0000_4000, 1'b1},
        '{3'd7, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_1111_2222_3333, 64'h0,                   1'b1},
        '{3'd0, 64'h0000_0000_12F0_7F03, 64'hC001_3FFF_8001_0FA0, 64'h0,                   1'b0},
        '{3'd1, 64'h0000_0000_FF80_4001, 64'h0000_0000_9C40_1234, 64'h0,                   1'b0},
        '{3'd2, 64'h0000_0000_FF80_4001, 64'h0000_0000_9C40_1234, 64'h0,                   1'b0},
        '{3'd3, 64'hA5C3_0F10_7788_FE01, 64'h1357_9BDF_8000_7FFF, 64'h0,                   1'b0},
        '{3'd4, 64'hA5C3_0F10_7788_FE01, 64'h1357_9BDF_8000_7FFF, 64'h0,                   1'b0},
        '{3'd5, 64'h0000_0000_AA01_BB80, 64'h0000_0000_F00D_C0DE, 64'h0,                   1'b0},
        '{3'd6, 64'h0000_0000_33CC_44EE, 64'h0000_0000_ABCD_7531, 64'h0,                   1'b0},
        '{3'd1, 64'h0000_0000_0102_0304, 64'h0000_0000_FFFF_0000, 64'h0,                   1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_mode = 3'd0;
    logic [63:0] in_opa = '0;
    logic [63:0] in_opb = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    frac_mul_simd dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_opa    (in_opa),
        .in_opb    (in_opb),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Reference: one rounded lane result, computed with integer arithmetic.
    function automatic logic [15:0] ref_lane(input logic [7:0] pix, input logic [15:0] coef);
        logic signed [15:0] c;
        int p;
        logic [31:0] pu;
        c  = coef;
        p  = int'(pix) * int'(c);
        pu = p;
        return pu[23:8] + {15'b0, pu[7]};
    endfunction

    // Reference model written from the requirements.
    function automatic logic [63:0] ref_model(input logic [2:0] m, input logic [63:0] a,
                                              input logic [63:0] b);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) begin
            case (m)
                3'd0: r[16*i +: 16] = ref_lane(a[8*i +: 8], b[16*i +: 16]);
                3'd1: r[16*i +: 16] = ref_lane(a[8*i +: 8], b[31:16]);
                3'd2: r[16*i +: 16] = ref_lane(a[8*i +: 8], b[15:0]);
                3'd3: r[16*i +: 16] = ref_lane(a[16*i+8 +: 8], b[16*i +: 16]);
                3'd4: r[16*i +: 16] = ref_lane(a[16*i +: 8], b[16*i +: 16]);
                3'd5: if (i < 2) r[32*i+7 +: 16] = ref_lane(a[16*i+8 +: 8], b[16*i +: 16]);
                3'd6: if (i < 2) r[32*i+7 +: 16] = ref_lane(a[16*i +: 8], b[16*i +: 16]);
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd1, 3'd2: return "R4";
            3'd3, 3'd4: return "R5";
            3'd5, 3'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one input and sample its result two edges later.
    task automatic run_one(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b,
                           output logic [63:0] got, output logic vld);
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; in_opa = a; in_opb = b;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        got = out_data;
        vld = out_valid;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] got, got2;
        logic        vld;
        logic [63:0] exp_burst [3];

        // R9: reset state.
        repeat (3) @(negedge clk);
        check("R9 valid", {63'b0, out_valid}, 64'h0);
        check("R9 data", out_data, 64'h0);
        rst_n = 1'b1;

        // Table walk: R1/R2 hand values, then all modes against the model.
        for (int k = 0; k < NVEC; k++) begin
            logic [63:0] exp;
            exp = VECS[k].use_exp ? VECS[k].exp : ref_model(VECS[k].mode, VECS[k].a, VECS[k].b);
            run_one(VECS[k].mode, VECS[k].a, VECS[k].b, got, vld);
            check("R8 valid", {63'b0, vld}, 64'h1);
            if (k == 0)      check("R1 hand lanes", got, exp);
            else if (k == 1) check("R2 wrap", got, exp);
            else             check(mode_tag(VECS[k].mode), got, exp);
        end

        // R1: zero coefficient gives zero in every lane.
        run_one(3'd0, 64'h0000_0000_FFFF_FFFF, 64'h0, got, vld);
        check("R1 zero coef", got, 64'h0);

        // R10: unread upper operand bits change nothing.
        run_one(3'd0, 64'hDEAD_BEEF_FFFF_0180, 64'h7FFF_8000_0080_0100, got, vld);
        check("R10 mode0 opa hi", got, 64'h7F7F_8080_0001_0080);
        run_one(3'd1, 64'h0000_0000_FF80_4001, 64'h0000_0000_9C40_1234, got, vld);
        run_one(3'd1, 64'h5555_AAAA_FF80_4001, 64'h1234_5678_9C40_1234, got2, vld);
        check("R10 mode1 hi bits", got2, got);
        run_one(3'd6, 64'hFFFF_FFFF_AA01_BB80, 64'hFFFF_FFFF_0080_0100, got, vld);
        check("R10 mode6 hi bits", got, 64'h0000_0080_0000_4000);

        // R8: back-to-back burst, in order, then hold on the idle cycle.
        exp_burst[0] = ref_model(3'd0, 64'h0000_0000_0102_0304, 64'h0100_0200_0300_0400);
        exp_burst[1] = ref_model(3'd3, 64'h8080_4040_2020_1010, 64'h7FFF_7FFF_8000_8000);
        exp_burst[2] = ref_model(3'd2, 64'h0000_0000_FFFE_FDFC, 64'h0000_0000_0000_FF00);
        @(negedge clk);
        in_valid = 1'b1; in_mode = 3'd0;
        in_opa = 64'h0000_0000_0102_0304; in_opb = 64'h0100_0200_0300_0400;
        @(negedge clk);
        check("R8 not early", {63'b0, out_valid}, 64'h0);
        in_mode = 3'd3; in_opa = 64'h8080_4040_2020_1010; in_opb = 64'h7FFF_7FFF_8000_8000;
        @(negedge clk);
        check("R8 burst 0 valid", {63'b0, out_valid}, 64'h1);
        check("R8 burst 0 data", out_data, exp_burst[0]);
        in_mode = 3'd2; in_opa = 64'h0000_0000_FFFE_FDFC; in_opb = 64'h0000_0000_0000_FF00;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 burst 1 data", out_data, exp_burst[1]);
        @(negedge clk);
        check("R8 burst 2 data", out_data, exp_burst[2]);
        @(negedge clk);
        check("R8 idle valid", {63'b0, out_valid}, 64'h0);
        check("R8 idle hold", out_data, exp_burst[2]);

        // R9: reset mid-run clears held data.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid-run valid", {63'b0, out_valid}, 64'h0);
        check("R9 mid-run data", out_data, 64'h0);
        rst_n = 1'b1;

        // R7: reserved code after reset, with all operand bits set.
        run_one(3'd7, '1, '1, got, vld);
        check("R7 all ones", got, 64'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule